// File: doc/BRIEF.md
# Key-Gated Flash Controller Register Bank

This block holds the three 16-bit control registers of an embedded flash controller and sits on a simple CPU register bus. Every write must carry the write key 0xA5 in its upper byte. A write with any other key changes nothing and raises a sticky key-violation flag. Every read returns the read key 0x96 in the upper byte. The lower bytes hold the following:

- the operation mode bits, which are also decoded into a single mode code for the sequencer;
- the timing-generator clock source and divider, which drive a tick generator built into the block;
- the lock, segment-A lock, emergency-exit and violation flags, next to the busy and wait status that the sequencer supplies.

Writing 1 to emergency exit clears every mode bit on the same edge, so the controller falls back to plain read mode. An access violation reported by the sequencer is latched until software clears it. It raises an interrupt request while the enable input is high.

Top module: `flash_ctl_regs`

## Requirements
- R1: A bus write whose bits 15:8 equal 0xA5 updates the register at its address: address 0 is the mode register, address 1 the clock register, address 2 the status register. Address 3 accepts no data.
- R2: A read from any address returns 0x96 in bits 15:8. Address 3 reads 0x9600.
- R3: A write whose bits 15:8 differ from 0xA5 leaves all three registers unchanged and sets the key-violation flag (status bit 1).
- R4: The key-violation flag clears only on a keyed status write with bit 1 at 0. A keyed status write with bit 1 at 1 leaves it as it was.
- R5: The mode register stores block write (bit 7), write (bit 6), global mass erase (bit 3), mass erase (bit 2) and erase (bit 1), and its other bits read 0. `mode_o` is derived from these bits as follows:
  - write set: 2 if block write is also set, otherwise 1;
  - write clear and mass erase set: 7 if global and erase are both set, 6 if only global is set, 5 if only erase is set, 4 if neither is set;
  - write and mass erase clear, erase set: 3;
  - all other combinations: 0.
- R6: The clock register holds the source select in bits 7:6 and the divider N in bits 5:0. Select 00 counts strobe 0, 01 counts strobe 1, and 10 and 11 both count strobe 2. `ftg_tick_o` pulses once per N+1 selected strobes. The count restarts when the clock register is written.
- R7: Status bit 4 is the lock bit. A keyed status write loads it, and `lock_o` follows it.
- R8: A keyed status write with bit 5 at 1 clears every mode bit on the same edge. Bit 5 reads back as written and drives `emer_exit_o`.
- R9: A pulse on `acc_viol_i` sets the access-violation flag (status bit 2). The flag stays set until a keyed status write with bit 2 at 0. `acc_irq_o` is the flag ANDed with `acc_irq_en_i`.
- R10: Status bit 6, the segment-A lock, flips on a keyed status write with bit 6 at 1 and is unchanged when bit 6 is 0.
- R11: Status bit 0 reads `seq_busy_i` and bit 3 reads `seq_wait_i`. Status bit 7 reads 0. Writes to these positions have no effect.
- R12: After reset the mode bits, divider, select, both violation flags, emergency exit and segment-A lock are 0, and lock is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data for bus_addr |
| seq_busy_i | input | 1 | Sequencer busy status |
| seq_wait_i | input | 1 | Sequencer ready-for-next-element status |
| acc_viol_i | input | 1 | Access violation pulse from sequencer |
| acc_irq_en_i | input | 1 | Access violation interrupt enable |
| src_stb_i | input | 3 | Clock source strobes |
| mode_o | output | 3 | Decoded operation mode |
| clk_sel_o | output | 2 | Clock source select field |
| div_o | output | 6 | Divider field |
| ftg_tick_o | output | 1 | Timing-generator tick |
| lock_o | output | 1 | Lock bit |
| seg_a_lock_o | output | 1 | Segment-A lock bit |
| emer_exit_o | output | 1 | Emergency-exit bit |
| acc_irq_o | output | 1 | Access violation interrupt request |

## Verification
Directed writes walk all 32 mode-bit combinations through the decoder. Directed writes also pair a keyed and an unkeyed write to the same register, which separates key gating from the write path itself. The tick generator runs at divider values 0, 2 and 63, under each of the four select codes. In each run only the matching strobe toggles, and a run with a mismatched strobe must yield no ticks. A random phase mixes keyed and unkeyed writes of random data to random addresses with violation pulses and random busy and wait levels. It exposes interactions between toggling, sticky flags and emergency clearing that the directed cases miss.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

   typedef enum logic [2:0] {
      MODE_READ       = 3'd0,
      MODE_WORD_WR    = 3'd1,
      MODE_BLOCK_WR   = 3'd2,
      MODE_SEG_ERASE  = 3'd3,
      MODE_MAIN_ERASE = 3'd4,
      MODE_ALL_ERASE  = 3'd5,
      MODE_GLB_MAIN   = 3'd6,
      MODE_GLB_ALL    = 3'd7
   } fmode_e;

   typedef struct packed {
      logic blk;
      logic wr;
      logic gm;
      logic me;
      logic er;
   } mode_bits_t;

   // bit positions inside the lower byte
   localparam int P_BLK   = 7;
   localparam int P_WR    = 6;
   localparam int P_GM    = 3;
   localparam int P_ME    = 2;
   localparam int P_ER    = 1;
   localparam int P_LOCKA = 6;
   localparam int P_EMEX  = 5;
   localparam int P_LOCK  = 4;
   localparam int P_WAIT  = 3;
   localparam int P_ACCV  = 2;
   localparam int P_KEYV  = 1;
   localparam int P_BUSY  = 0;

endpackage

// File: rtl/fctl_keygate.sv
module fctl_keygate #(
   parameter int                ADDR_W = 2,
   parameter int                N_REG  = 3,
   parameter int                KEY_W  = 8,
   parameter logic [KEY_W-1:0]  WR_KEY = 8'hA5
) (
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [KEY_W-1:0]  key_i,
   output logic [N_REG-1:0]  stb_o,
   output logic              bad_o
);

   logic key_ok;
   assign key_ok = (key_i == WR_KEY);
   assign bad_o  = bus_we && !key_ok;

   for (genvar g = 0; g < N_REG; g++) begin : g_stb
      assign stb_o[g] = bus_we && key_ok && (bus_addr == ADDR_W'(g));
   end

endmodule

// File: rtl/fctl_mode_reg.sv
module fctl_mode_reg
   import flash_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic       clr_i,
   input  mode_bits_t wd_i,
   output mode_bits_t bits_o,
   output fmode_e     mode_o
);

   mode_bits_t bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bits_q <= '0;
      else if (clr_i) bits_q <= '0;
      else if (we_i)  bits_q <= wd_i;
   end

   always_comb begin
      mode_o = MODE_READ;
      if (bits_q.wr)
         mode_o = bits_q.blk ? MODE_BLOCK_WR : MODE_WORD_WR;
      else if (bits_q.me) begin
         if (bits_q.gm) mode_o = bits_q.er ? MODE_GLB_ALL : MODE_GLB_MAIN;
         else           mode_o = bits_q.er ? MODE_ALL_ERASE : MODE_MAIN_ERASE;
      end else if (bits_q.er)
         mode_o = MODE_SEG_ERASE;
   end

   assign bits_o = bits_q;

   // R8
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (bits_q == '0));
   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i && !clr_i) |=> $stable(bits_q));

endmodule

// File: rtl/fctl_clk_cfg.sv
module fctl_clk_cfg #(
   parameter int N_SRC = 3,
   parameter int SEL_W = 2,
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [SEL_W-1:0] sel_wd_i,
   input  logic [DIV_W-1:0] div_wd_i,
   input  logic [N_SRC-1:0] src_stb_i,
   output logic [SEL_W-1:0] sel_o,
   output logic [DIV_W-1:0] div_o,
   output logic             tick_o
);

   if (N_SRC < 1 || N_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("fctl_clk_cfg: N_SRC must fit the select field");
   end

   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             tick_q;
   logic             pick;

   always_comb begin
      pick = src_stb_i[N_SRC-1];
      for (int i = 0; i < N_SRC; i++)
         if (sel_q == SEL_W'(i)) pick = src_stb_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         div_q  <= '0;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (we_i) begin
         sel_q  <= sel_wd_i;
         div_q  <= div_wd_i;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (pick) begin
         if (cnt_q >= div_q) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
         end
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign sel_o  = sel_q;
   assign div_o  = div_q;
   assign tick_o = tick_q;

   // R6
   tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i && !pick) |=> !tick_q);
   // R6
   tick_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> (cnt_q == '0));

endmodule

// File: rtl/fctl_status_reg.sv
module fctl_status_reg #(
   parameter logic LOCK_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we_i,
   input  logic bad_key_i,
   input  logic wd_locka_i,
   input  logic wd_emex_i,
   input  logic wd_lock_i,
   input  logic wd_accv_i,
   input  logic wd_keyv_i,
   input  logic acc_viol_i,
   output logic locka_o,
   output logic emex_o,
   output logic lock_o,
   output logic accv_o,
   output logic keyv_o,
   output logic emex_clr_o
);

   logic locka_q, emex_q, lock_q, accv_q, keyv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locka_q <= 1'b0;
         emex_q  <= 1'b0;
         lock_q  <= LOCK_RST;
         accv_q  <= 1'b0;
         keyv_q  <= 1'b0;
      end else begin
         if (we_i) begin
            lock_q  <= wd_lock_i;
            emex_q  <= wd_emex_i;
            locka_q <= locka_q ^ wd_locka_i;
            keyv_q  <= keyv_q & wd_keyv_i;
         end else if (bad_key_i) begin
            keyv_q  <= 1'b1;
         end
         if (acc_viol_i)  accv_q <= 1'b1;
         else if (we_i)   accv_q <= wd_accv_i;
      end
   end

   assign locka_o    = locka_q;
   assign emex_o     = emex_q;
   assign lock_o     = lock_q;
   assign accv_o     = accv_q;
   assign keyv_o     = keyv_q;
   assign emex_clr_o = we_i && wd_emex_i;

   // R3
   keyv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_key_i |=> keyv_q);
   // R4
   keyv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (keyv_q && !(we_i && !wd_keyv_i)) |=> keyv_q);
   // R10
   locka_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && wd_locka_i) |=> $stable(locka_q));
   // R9
   accv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(accv_q) |-> ($past(acc_viol_i) || $past(we_i)));

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
   import flash_ctl_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               ADDR_W   = 2,
   parameter int               N_SRC    = 3,
   parameter logic [7:0]       WR_KEY   = 8'hA5,
   parameter logic [7:0]       RD_KEY   = 8'h96,
   parameter logic             LOCK_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              seq_busy_i,
   input  logic              seq_wait_i,
   input  logic              acc_viol_i,
   input  logic              acc_irq_en_i,
   input  logic [N_SRC-1:0]  src_stb_i,
   output logic [2:0]        mode_o,
   output logic [1:0]        clk_sel_o,
   output logic [5:0]        div_o,
   output logic              ftg_tick_o,
   output logic              lock_o,
   output logic              seg_a_lock_o,
   output logic              emer_exit_o,
   output logic              acc_irq_o
);

   localparam int LO_W  = DATA_W / 2;
   localparam int N_REG = 3;

   if (DATA_W != 16) begin : g_bad_width
      $error("flash_ctl_regs: DATA_W must be 16");
   end
   if ((1 << ADDR_W) < N_REG) begin : g_bad_addr
      $error("flash_ctl_regs: ADDR_W too narrow for the register count");
   end

   logic [N_REG-1:0] stb;
   logic             bad_key;
   logic [LO_W-1:0]  wd;
   mode_bits_t       mode_wd, mode_bits;
   fmode_e           mode_dec;
   logic             locka, emex, lock, accv, keyv, emex_clr;

   assign wd = bus_wdata[LO_W-1:0];

   fctl_keygate #(.ADDR_W(ADDR_W), .N_REG(N_REG), .KEY_W(DATA_W-LO_W), .WR_KEY(WR_KEY))
   u_keygate (
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .key_i    (bus_wdata[DATA_W-1:LO_W]),
      .stb_o    (stb),
      .bad_o    (bad_key)
   );

   assign mode_wd = '{blk: wd[P_BLK], wr: wd[P_WR], gm: wd[P_GM], me: wd[P_ME], er: wd[P_ER]};

   fctl_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (stb[0]),
      .clr_i  (emex_clr),
      .wd_i   (mode_wd),
      .bits_o (mode_bits),
      .mode_o (mode_dec)
   );

   fctl_clk_cfg #(.N_SRC(N_SRC), .SEL_W(2), .DIV_W(6)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (stb[1]),
      .sel_wd_i  (wd[7:6]),
      .div_wd_i  (wd[5:0]),
      .src_stb_i (src_stb_i),
      .sel_o     (clk_sel_o),
      .div_o     (div_o),
      .tick_o    (ftg_tick_o)
   );

   fctl_status_reg #(.LOCK_RST(LOCK_RST)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (stb[2]),
      .bad_key_i  (bad_key),
      .wd_locka_i (wd[P_LOCKA]),
      .wd_emex_i  (wd[P_EMEX]),
      .wd_lock_i  (wd[P_LOCK]),
      .wd_accv_i  (wd[P_ACCV]),
      .wd_keyv_i  (wd[P_KEYV]),
      .acc_viol_i (acc_viol_i),
      .locka_o    (locka),
      .emex_o     (emex),
      .lock_o     (lock),
      .accv_o     (accv),
      .keyv_o     (keyv),
      .emex_clr_o (emex_clr)
   );

   always_comb begin
      logic [LO_W-1:0] lo;
      lo = '0;
      case (bus_addr)
         ADDR_W'(0): begin
            lo[P_BLK] = mode_bits.blk;
            lo[P_WR]  = mode_bits.wr;
            lo[P_GM]  = mode_bits.gm;
            lo[P_ME]  = mode_bits.me;
            lo[P_ER]  = mode_bits.er;
         end
         ADDR_W'(1): lo = {clk_sel_o, div_o};
         ADDR_W'(2): begin
            lo[P_LOCKA] = locka;
            lo[P_EMEX]  = emex;
            lo[P_LOCK]  = lock;
            lo[P_WAIT]  = seq_wait_i;
            lo[P_ACCV]  = accv;
            lo[P_KEYV]  = keyv;
            lo[P_BUSY]  = seq_busy_i;
         end
         default: lo = '0;
      endcase
      bus_rdata = {RD_KEY, lo};
   end

   assign mode_o       = mode_dec;
   assign lock_o       = lock;
   assign seg_a_lock_o = locka;
   assign emer_exit_o  = emex;
   assign acc_irq_o    = accv && acc_irq_en_i;

   // R1
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_irq_en_i |-> !acc_irq_o);

endmodule

// File: tb/flash_ctl_regs_bench.sv
module flash_ctl_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        seq_busy_i = 1'b0, seq_wait_i = 1'b0;
   logic        acc_viol_i = 1'b0, acc_irq_en_i = 1'b0;
   logic [2:0]  src_stb_i = '0;
   logic [2:0]  mode_o;
   logic [1:0]  clk_sel_o;
   logic [5:0]  div_o;
   logic        ftg_tick_o, lock_o, seg_a_lock_o, emer_exit_o, acc_irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m_r1, m_r2;
   logic       m_locka, m_emex, m_lock, m_accv, m_keyv;

   always #2 clk = ~clk;

   flash_ctl_regs u_flash_ctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy_i(seq_busy_i),
      .seq_wait_i(seq_wait_i), .acc_viol_i(acc_viol_i), .acc_irq_en_i(acc_irq_en_i),
      .src_stb_i(src_stb_i), .mode_o(mode_o), .clk_sel_o(clk_sel_o), .div_o(div_o),
      .ftg_tick_o(ftg_tick_o), .lock_o(lock_o), .seg_a_lock_o(seg_a_lock_o),
      .emer_exit_o(emer_exit_o), .acc_irq_o(acc_irq_o)
   );

   function automatic logic [2:0] exp_mode(input logic [7:0] r);
      if (r[6])      return r[7] ? 3'd2 : 3'd1;
      else if (r[2]) begin
         if (r[3])   return r[1] ? 3'd7 : 3'd6;
         else        return r[1] ? 3'd5 : 3'd4;
      end
      else if (r[1]) return 3'd3;
      return 3'd0;
   endfunction

   function automatic logic [15:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return {8'h96, m_r1};
         2'd1:    return {8'h96, m_r2};
         2'd2:    return {8'h96, 1'b0, m_locka, m_emex, m_lock, seq_wait_i,
                          m_accv, m_keyv, seq_busy_i};
         default: return 16'h9600;
      endcase
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_write(input logic [1:0] a, input logic [15:0] d);
      if (d[15:8] != 8'hA5) m_keyv = 1'b1;
      else case (a)
         2'd0: m_r1 = d[7:0] & 8'hCE;
         2'd1: m_r2 = d[7:0];
         2'd2: begin
            m_lock  = d[4];
            m_emex  = d[5];
            if (d[5]) m_r1 = 8'h00;
            m_keyv  = m_keyv & d[1];
            m_accv  = d[2];
            m_locka = m_locka ^ d[6];
         end
         default: ;
      endcase
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic av);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; acc_viol_i = av;
      @(posedge clk); #1;
      model_write(a, d);
      if (av) m_accv = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; acc_viol_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 chk(bus_rdata, exp_read(a), tag);
   endtask

   task automatic check_outs(input string tag);
      #1;
      chk({13'd0, mode_o}, {13'd0, exp_mode(m_r1)}, {tag, " mode"});
      chk({15'd0, lock_o}, {15'd0, m_lock}, {tag, " lock"});
      chk({15'd0, acc_irq_o}, {15'd0, m_accv & acc_irq_en_i}, {tag, " irq"});
      chk({15'd0, seg_a_lock_o}, {15'd0, m_locka}, {tag, " locka"});
      chk({15'd0, emer_exit_o}, {15'd0, m_emex}, {tag, " emex"});
      chk({8'd0, clk_sel_o, div_o}, {8'd0, m_r2}, {tag, " clkcfg"});
   endtask

   task automatic tick_run(input logic [1:0] sel, input logic [5:0] dv,
                           input logic [2:0] mask, input int k, input int expn);
      int n;
      wr(2'd1, {8'hA5, sel, dv}, 1'b0);
      src_stb_i = mask;
      n = 0;
      repeat ((int'(dv) + 1) * k) begin
         @(posedge clk); #1;
         if (ftg_tick_o) n++;
      end
      src_stb_i = '0;
      chk(16'(n), 16'(expn), "R6 tick count");
   endtask

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      m_r1 = 0; m_r2 = 0; m_locka = 0; m_emex = 0; m_lock = 1; m_accv = 0; m_keyv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12 reset state, R2 read key
      rd(2'd0, "R12 r1 reset");
      rd(2'd1, "R12 r2 reset");
      rd(2'd2, "R12 r3 reset");
      rd(2'd3, "R2 addr3 read");
      check_outs("R12");

      // R1 R5 all mode combinations
      for (int c = 0; c < 32; c++) begin
         logic [7:0] v;
         v = {c[4], c[3], 2'b11, c[2], c[1], c[0], 1'b1};
         wr(2'd0, {8'hA5, v}, 1'b0);
         rd(2'd0, "R5 mode reg read");
         check_outs("R5");
      end

      // R3 wrong key leaves register, sets flag
      wr(2'd0, 16'hA540, 1'b0);
      wr(2'd0, 16'h5A86, 1'b0);
      rd(2'd0, "R3 r1 unchanged");
      rd(2'd2, "R3 keyv set");
      wr(2'd1, 16'h96FF, 1'b0);
      rd(2'd1, "R3 r2 unchanged");
      // R4 keyv sticky vs cleared
      wr(2'd2, 16'hA502, 1'b0);
      rd(2'd2, "R4 keyv kept");
      wr(2'd2, 16'hA500, 1'b0);
      rd(2'd2, "R4 keyv cleared");
      // R7 lock
      wr(2'd2, 16'hA510, 1'b0);
      rd(2'd2, "R7 lock set");
      check_outs("R7");
      // R8 emergency exit
      wr(2'd0, 16'hA5CE, 1'b0);
      wr(2'd2, 16'hA520, 1'b0);
      rd(2'd0, "R8 r1 cleared");
      rd(2'd2, "R8 emex reads");
      check_outs("R8");
      // R10 segment-A lock toggling
      wr(2'd2, 16'hA540, 1'b0);
      rd(2'd2, "R10 toggle on");
      wr(2'd2, 16'hA500, 1'b0);
      rd(2'd2, "R10 no toggle");
      wr(2'd2, 16'hA540, 1'b0);
      rd(2'd2, "R10 toggle off");
      // R11 busy/wait from inputs, writes ignored
      seq_busy_i = 1'b1; seq_wait_i = 1'b1;
      wr(2'd2, 16'hA500, 1'b0);
      rd(2'd2, "R11 status inputs high");
      seq_busy_i = 1'b0; seq_wait_i = 1'b0;
      wr(2'd2, 16'hA589, 1'b0);
      rd(2'd2, "R11 write to busy wait ignored");
      // R9 access violation
      acc_irq_en_i = 1'b0;
      wr(2'd3, 16'hA500, 1'b1);
      rd(2'd2, "R9 accv set");
      check_outs("R9 masked");
      acc_irq_en_i = 1'b1;
      check_outs("R9 enabled");
      wr(2'd2, 16'hA504, 1'b0);
      rd(2'd2, "R9 accv kept");
      wr(2'd2, 16'hA500, 1'b0);
      rd(2'd2, "R9 accv cleared");
      check_outs("R9 cleared");

      // R6 divider and source select
      tick_run(2'b00, 6'd0,  3'b001, 5, 5);
      tick_run(2'b01, 6'd2,  3'b010, 4, 4);
      tick_run(2'b10, 6'd63, 3'b100, 2, 2);
      tick_run(2'b11, 6'd2,  3'b100, 3, 3);
      tick_run(2'b00, 6'd1,  3'b110, 4, 0);
      check_outs("R6 cfg");

      // random phase
      for (int it = 0; it < 400; it++) begin
         logic [1:0]  a;
         logic [15:0] d;
         a = 2'($urandom_range(0, 3));
         d = 16'($urandom);
         if ($urandom_range(0, 3) != 0) d[15:8] = 8'hA5;
         seq_busy_i   = 1'($urandom);
         seq_wait_i   = 1'($urandom);
         acc_irq_en_i = 1'($urandom);
         wr(a, d, ($urandom_range(0, 7) == 0));
         rd(2'd0, "R1 random r1");
         rd(2'd1, "R1 random r2");
         rd(2'd2, "R3 random r3");
         check_outs("R1 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule